// File: doc/BRIEF.md
# Rotate, Shift and Single-Bit Unit

This purely combinational unit serves the execution stage of a small 8-bit core. It handles two groups of operations. The first is the two-byte group of rotates, shifts, nibble swap and single-bit test, clear and set. The second is the short one-byte rotates that act on the accumulator. The core presents an operand byte, a bit index, the current carry flag, an operation code and a marker for the accumulator forms. In the same cycle the unit returns the new byte, the new Z, N, H and C flag values, a write strobe for the result, and one write strobe per flag.

The caller uses the flag strobes to update only the flags an operation is allowed to touch. It uses the result strobe to decide whether the destination is written. Sequencing of memory read-modify-write forms belongs to the controller and is not handled here.

Top module: `rsb_unit`

## Requirements
- R1: Op code 0 rotates left, with bit 7 copied into bit 0 and into C. Op code 1 rotates right, with bit 0 copied into bit 7 and into C.
- R2: Op code 2 rotates left through carry: carry_i enters bit 0 and the old bit 7 becomes C. Op code 3 rotates right through carry: carry_i enters bit 7 and the old bit 0 becomes C.
- R3: Op code 4 shifts left with 0 entering bit 0. Op code 5 shifts right and keeps bit 7. Op code 6 shifts right with 0 entering bit 7. In all three, the bit shifted out becomes C.
- R4: Op code 7 exchanges the upper and lower nibbles. It sets Z when the result is zero and outputs N=0, H=0 and C=0.
- R5: For op codes 0..7 with acc_form_i low, res_we_o is 1 and flag_we_o is 4'b1111 (bit order Z,N,H,C from bit 3 down to bit 0). Z is 1 exactly when the result is zero, and N=H=0.
- R6: With acc_form_i high, op codes 0..3 give the same result and C as in R1/R2, but Z=N=H=0. For op codes 4..15, acc_form_i has no effect on any output.
- R7: Op code 8 tests the bit selected by bit_sel_i (0..7). It outputs Z=1 when that bit is 0, N=0, H=1 and C=carry_i, with flag_we_o=4'b1110, res_we_o=0 and res_o equal to the operand.
- R8: Op code 9 clears and op code 10 sets the bit selected by bit_sel_i, leaving the other bits unchanged. res_we_o=1 and flag_we_o=0, and the flag outputs are Z=N=H=0 with C=carry_i.
- R9: Op codes 11..15 give res_o equal to the operand, res_we_o=0 and flag_we_o=0, with Z=N=H=0 and C=carry_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte |
| bit_sel_i | input | 3 | Bit index for test, clear and set |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| acc_form_i | input | 1 | Marks the one-byte accumulator rotate forms |
| res_o | output | 8 | Result byte |
| z_o | output | 1 | New zero flag |
| n_o | output | 1 | New subtract flag |
| h_o | output | 1 | New half-carry flag |
| c_o | output | 1 | New carry flag |
| res_we_o | output | 1 | Result write strobe |
| flag_we_o | output | 4 | Flag write strobes, Z,N,H,C from bit 3 down |

## Verification
Immediate assertions in the top module check several rules whenever the inputs change. For prefixed rotates and shifts, Z must follow a zero result. Accumulator rotates must never raise Z. A bit test must never write the result. Clear and set must change at most one bit and write no flag. Unused codes must leave everything untouched. The exact bit movement of each rotate and shift cannot be checked that way: which bit reaches C, what enters the vacated end, and which bit the index selects. Only the bench shows these, by sweeping every operand, index and carry value against its own model and adding directed corner bytes such as 0x80, 0x01 and 0x81.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam logic [3:0] OP_RLC  = 4'd0;
  localparam logic [3:0] OP_RRC  = 4'd1;
  localparam logic [3:0] OP_RL   = 4'd2;
  localparam logic [3:0] OP_RR   = 4'd3;
  localparam logic [3:0] OP_SLA  = 4'd4;
  localparam logic [3:0] OP_SRA  = 4'd5;
  localparam logic [3:0] OP_SRL  = 4'd6;
  localparam logic [3:0] OP_SWAP = 4'd7;
  localparam logic [3:0] OP_BIT  = 4'd8;
  localparam logic [3:0] OP_RES  = 4'd9;
  localparam logic [3:0] OP_SET  = 4'd10;

  // flag strobe positions
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;
endpackage

// File: rtl/rsb_shift.sv
module rsb_shift
  import rsb_pkg::*;
#(
  parameter int W = 8,
  localparam int HW = W / 2
) (
  input  logic [W-1:0] opnd_i,
  input  logic         carry_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  always_comb begin
    res_o  = opnd_i;
    cout_o = carry_i;
    case (op_i)
      OP_RLC: begin
        res_o  = {opnd_i[W-2:0], opnd_i[W-1]};
        cout_o = opnd_i[W-1];
      end
      OP_RRC: begin
        res_o  = {opnd_i[0], opnd_i[W-1:1]};
        cout_o = opnd_i[0];
      end
      OP_RL: begin
        res_o  = {opnd_i[W-2:0], carry_i};
        cout_o = opnd_i[W-1];
      end
      OP_RR: begin
        res_o  = {carry_i, opnd_i[W-1:1]};
        cout_o = opnd_i[0];
      end
      OP_SLA: begin
        res_o  = {opnd_i[W-2:0], 1'b0};
        cout_o = opnd_i[W-1];
      end
      OP_SRA: begin
        res_o  = {opnd_i[W-1], opnd_i[W-1:1]};
        cout_o = opnd_i[0];
      end
      OP_SRL: begin
        res_o  = {1'b0, opnd_i[W-1:1]};
        cout_o = opnd_i[0];
      end
      OP_SWAP: begin
        res_o  = {opnd_i[HW-1:0], opnd_i[W-1:HW]};
        cout_o = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
  import rsb_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     opnd_i,
  input  logic [IDX_W-1:0] sel_i,
  input  logic [3:0]       op_i,
  output logic [W-1:0]     res_o,
  output logic             bit_o
);
  logic [W-1:0] mask;

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask[g] = (sel_i == IDX_W'(g));
  end

  assign bit_o = |(opnd_i & mask);

  always_comb begin
    case (op_i)
      OP_RES:  res_o = opnd_i & ~mask;
      OP_SET:  res_o = opnd_i | mask;
      default: res_o = opnd_i;
    endcase
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     opnd_i,
  input  logic [IDX_W-1:0] bit_sel_i,
  input  logic             carry_i,
  input  logic [3:0]       op_i,
  input  logic             acc_form_i,
  output logic [W-1:0]     res_o,
  output logic             z_o,
  output logic             n_o,
  output logic             h_o,
  output logic             c_o,
  output logic             res_we_o,
  output logic [3:0]       flag_we_o
);
  logic [W-1:0] sh_res, bo_res;
  logic         sh_c, bo_bit;
  logic         is_shift, acc_rot;

  rsb_shift #(.W(W)) u_shift (
    .opnd_i (opnd_i),
    .carry_i(carry_i),
    .op_i   (op_i),
    .res_o  (sh_res),
    .cout_o (sh_c)
  );

  rsb_bitop #(.W(W)) u_bitop (
    .opnd_i(opnd_i),
    .sel_i (bit_sel_i),
    .op_i  (op_i),
    .res_o (bo_res),
    .bit_o (bo_bit)
  );

  assign is_shift = (op_i <= OP_SWAP);
  assign acc_rot  = acc_form_i && (op_i <= OP_RR);

  always_comb begin
    res_o     = opnd_i;
    z_o       = 1'b0;
    n_o       = 1'b0;
    h_o       = 1'b0;
    c_o       = carry_i;
    res_we_o  = 1'b0;
    flag_we_o = '0;
    if (is_shift) begin
      res_o     = sh_res;
      res_we_o  = 1'b1;
      flag_we_o = 4'b1111;
      z_o       = acc_rot ? 1'b0 : (sh_res == '0);
      c_o       = sh_c;
    end else if (op_i == OP_BIT) begin
      z_o           = ~bo_bit;
      h_o           = 1'b1;
      flag_we_o     = 4'b1110;
    end else if (op_i == OP_RES || op_i == OP_SET) begin
      res_o    = bo_res;
      res_we_o = 1'b1;
    end
  end

  always_comb begin
    if (is_shift && !acc_form_i)
      a_r5_zero_tracks_result: assert (z_o == (res_o == '0) && !n_o && !h_o);
    if (acc_rot)
      a_r6_acc_z_clear: assert (!z_o && !n_o && !h_o);
    if (op_i == OP_SWAP)
      a_r4_swap_no_carry: assert (!c_o && flag_we_o[FC]);
    if (op_i == OP_BIT)
      a_r7_test_no_write: assert (!res_we_o && res_o == opnd_i && c_o == carry_i && h_o);
    if (op_i == OP_RES || op_i == OP_SET)
      a_r8_single_bit: assert ($countones(res_o ^ opnd_i) <= 1 && flag_we_o == '0);
    if (op_i > OP_SET)
      a_r9_unused_idle: assert (!res_we_o && flag_we_o == '0 && res_o == opnd_i);
  end
endmodule

// File: tb/sim_rsb_unit.sv
module sim_rsb_unit;
  typedef struct packed {
    logic [7:0] r;
    logic       z, n, h, c, rwe;
    logic [3:0] fwe;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] opnd;
  logic [2:0] bsel;
  logic       cin, acc;
  logic [3:0] op;
  logic [7:0] res;
  logic       z, n, h, c, rwe;
  logic [3:0] fwe;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  rsb_unit u0 (
    .opnd_i(opnd), .bit_sel_i(bsel), .carry_i(cin), .op_i(op), .acc_form_i(acc),
    .res_o(res), .z_o(z), .n_o(n), .h_o(h), .c_o(c), .res_we_o(rwe), .flag_we_o(fwe)
  );

  function automatic exp_t model(logic [3:0] o, logic [7:0] d, logic [2:0] b, logic ci, logic ac);
    exp_t e;
    e = '{r: d, z: 1'b0, n: 1'b0, h: 1'b0, c: ci, rwe: 1'b0, fwe: 4'b0000};
    if (o <= 4'd7) begin
      case (o)
        4'd0: begin e.r = 8'((d << 1) | (d >> 7)); e.c = d[7]; end
        4'd1: begin e.r = 8'((d >> 1) | (d << 7)); e.c = d[0]; end
        4'd2: begin e.r = 8'((d << 1) | {7'd0, ci}); e.c = d[7]; end
        4'd3: begin e.r = 8'((d >> 1) | ({7'd0, ci} << 7)); e.c = d[0]; end
        4'd4: begin e.r = 8'(d << 1); e.c = d[7]; end
        4'd5: begin e.r = 8'((d >> 1) | (d & 8'h80)); e.c = d[0]; end
        4'd6: begin e.r = 8'(d >> 1); e.c = d[0]; end
        default: begin e.r = 8'((d << 4) | (d >> 4)); e.c = 1'b0; end
      endcase
      e.z   = (ac && o <= 4'd3) ? 1'b0 : (e.r == 8'd0);
      e.rwe = 1'b1;
      e.fwe = 4'b1111;
    end else if (o == 4'd8) begin
      e.z = ((d >> b) & 8'd1) == 8'd0;
      e.h = 1'b1;
      e.fwe = 4'b1110;
    end else if (o == 4'd9) begin
      e.r = d & ~(8'd1 << b); e.rwe = 1'b1;
    end else if (o == 4'd10) begin
      e.r = d | (8'd1 << b); e.rwe = 1'b1;
    end
    return e;
  endfunction

  function automatic string res_tag(logic [3:0] o);
    if (o <= 4'd1) return "R1";
    if (o <= 4'd3) return "R2";
    if (o <= 4'd6) return "R3";
    if (o == 4'd7) return "R4";
    if (o == 4'd8) return "R7";
    if (o <= 4'd10) return "R8";
    return "R9";
  endfunction

  function automatic string flag_tag(logic [3:0] o, logic ac);
    if (o <= 4'd3 && ac) return "R6";
    if (o <= 4'd6) return "R5";
    return res_tag(o);
  endfunction

  task automatic check(string tag, exp_t act, exp_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d opnd=%h bit=%0d cin=%0b acc=%0b act=%h exp=%h",
               tag, op, opnd, bsel, cin, acc, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] o, logic [7:0] d, logic [2:0] b, logic ci, logic ac);
    exp_t e, a;
    @(posedge clk);
    op = o; opnd = d; bsel = b; cin = ci; acc = ac;
    @(negedge clk);
    e = model(o, d, b, ci, ac);
    a = '{r: res, z: z, n: n, h: h, c: c, rwe: rwe, fwe: fwe};
    check(res_tag(o), '{r: a.r, z: 1'b0, n: 1'b0, h: 1'b0, c: 1'b0, rwe: a.rwe, fwe: 4'd0},
                      '{r: e.r, z: 1'b0, n: 1'b0, h: 1'b0, c: 1'b0, rwe: e.rwe, fwe: 4'd0});
    check(flag_tag(o, ac), a, e);
  endtask

  task automatic directed(string tag, logic [3:0] o, logic [7:0] d, logic ci, logic ac,
                          logic [7:0] xr, logic xz, logic xc);
    @(posedge clk);
    op = o; opnd = d; bsel = 3'd0; cin = ci; acc = ac;
    @(negedge clk);
    check(tag, '{r: res, z: z, n: 1'b0, h: 1'b0, c: c, rwe: 1'b0, fwe: 4'd0},
               '{r: xr, z: xz, n: 1'b0, h: 1'b0, c: xc, rwe: 1'b0, fwe: 4'd0});
  endtask

  initial begin
    op = 4'd15; opnd = 8'h5A; bsel = 3'd0; cin = 1'b1; acc = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state with an unused code: R9
    check("R9", '{r: res, z: z, n: n, h: h, c: c, rwe: rwe, fwe: fwe},
                '{r: 8'h5A, z: 1'b0, n: 1'b0, h: 1'b0, c: 1'b1, rwe: 1'b0, fwe: 4'd0});

    // directed corners
    directed("R1", 4'd0, 8'h80, 1'b0, 1'b0, 8'h01, 1'b0, 1'b1);
    directed("R1", 4'd1, 8'h01, 1'b0, 1'b0, 8'h80, 1'b0, 1'b1);
    directed("R2", 4'd3, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    directed("R2", 4'd2, 8'h00, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0);
    directed("R3", 4'd5, 8'h81, 1'b0, 1'b0, 8'hC0, 1'b0, 1'b1);
    directed("R3", 4'd4, 8'h80, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    directed("R4", 4'd7, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);
    directed("R6", 4'd0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
    directed("R6", 4'd3, 8'h01, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1);

    // exhaustive sweep of operands, carries and accumulator marker
    for (int o = 0; o < 16; o++)
      for (int d = 0; d < 256; d++)
        for (int ci = 0; ci < 2; ci++)
          for (int ac = 0; ac < 2; ac++)
            if (o >= 8 && o <= 10) begin
              for (int b = 0; b < 8; b++)
                apply(4'(o), 8'(d), 3'(b), 1'(ci), 1'(ac));
            end else if (o <= 7 || (ci == 0 && ac == 0)) begin
              apply(4'(o), 8'(d), 3'(d), 1'(ci), 1'(ac));
            end

    // random mix
    void'($urandom(32'd20250));
    for (int i = 0; i < 3000; i++)
      apply(4'($urandom), 8'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule